// File: doc/BRIEF.md
# Port Status LED Controller

This block drives the four status indicators of one network port. Two indicators show whether the link is up at the higher or the lower speed. A third blinks while frames are sent or received. The fourth has two roles, chosen by a mode input: it either stays lit while the port runs full duplex, or it blinks faster while collisions occur. All inputs are single-cycle pulses or level signals in the system clock domain. All outputs are active low and registered.

The blink timing comes from the system clock frequency, set by the `CLK_HZ` parameter. The activity period is `CLK_HZ/10` cycles and the collision period is `CLK_HZ/20` cycles, both in whole cycles. A blink channel stays running for one full period after its last event, so a one-cycle pulse still gives a visible on/off flash. A blink starts at the lit phase when an event arrives while the channel is idle. Later events inside the window only extend it and do not move the phase.

Top module: `port_led_ctrl`

## Requirements
- R1: `led_fast_n` is driven 0 (lit) when `link_up` and `speed_100` are both 1, and 1 otherwise. Every LED output follows its inputs one clock later.
- R2: `led_slow_n` is driven 0 when `link_up` is 1 and `speed_100` is 0, and 1 otherwise.
- R3: An activity event is a cycle in which `tx_act` or `rx_act` is 1 while `link_up` is 1. The activity blink period is P = `CLK_HZ/10` cycles. If the event arrives while the channel is idle, the blink starts at phase 0. `led_act_n` is 0 in the first floor(P/2) cycles of each period and 1 in the rest.
- R4: A blink channel stays active for exactly P cycles after its most recent event, counting from that event's edge. An event inside the window reloads the window but does not reset the phase. A single pulse therefore gives floor(P/2) lit cycles followed by P-floor(P/2) dark cycles.
- R5: When `col_mode` is 0, `led_dxcol_n` is 0 exactly when `link_up` and `full_duplex` are both 1.
- R6: When `col_mode` is 1, `led_dxcol_n` shows the collision blink. Its period is `CLK_HZ/20` cycles and it follows the same start and stretch rules as R3 and R4. `col_evt` pulses are accepted whatever the link state.
- R7: While `rst_n` is 0, all four LED outputs are 1 (dark), and all blink channels are idle.
- R8: While `link_up` is 0, `led_fast_n`, `led_slow_n` and `led_act_n` are 1. Activity pulses seen during link down are discarded, so they cause no blink after the link returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | Link good level |
| speed_100 | input | 1 | 1 = higher speed link, 0 = lower speed |
| full_duplex | input | 1 | Full-duplex level |
| tx_act | input | 1 | Transmit activity pulse or level |
| rx_act | input | 1 | Receive activity pulse or level |
| col_evt | input | 1 | Collision pulse or level |
| col_mode | input | 1 | Fourth LED role: 0 duplex, 1 collision blink |
| led_fast_n | output | 1 | Higher speed link LED, active low |
| led_slow_n | output | 1 | Lower speed link LED, active low |
| led_act_n | output | 1 | Activity LED, active low |
| led_dxcol_n | output | 1 | Duplex or collision LED, active low |

## Verification
A wrong phase counter shows up on the activity or collision LED within half a period of the first event after idle. The lit stretch comes out too long or too short, or it starts dark. A wrong window counter shows when a single isolated pulse gives more or fewer lit cycles than floor(P/2), or when the LED keeps blinking past P cycles after the last event. The bench therefore checks every output in every cycle against a model that tracks event edges. A wrong link gate or a missing gate on the activity events shows right after link-up: the activity LED lights with no new traffic.

// File: rtl/led_ctrl_pkg.sv
package led_ctrl_pkg;

  // Number of system cycles in one blink period at the given rate.
  function automatic int unsigned blink_cycles(input int unsigned clk_hz,
                                               input int unsigned rate_hz);
    return clk_hz / rate_hz;
  endfunction

  // Lit part of a period: the leading half, rounded down.
  function automatic int unsigned lit_cycles(input int unsigned period);
    return period / 2;
  endfunction

  // Bits needed to hold values 0..n.
  function automatic int unsigned count_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  typedef enum logic [1:0] {
    LED_FAST  = 2'd0,
    LED_SLOW  = 2'd1,
    LED_ACT   = 2'd2,
    LED_DXCOL = 2'd3
  } led_idx_e;

endpackage

// File: rtl/blink_stretch.sv
module blink_stretch
  import led_ctrl_pkg::*;
#(
  parameter int unsigned PERIOD = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  output logic busy,
  output logic lit
);
  localparam int unsigned W  = count_bits(PERIOD);
  localparam int unsigned ON = lit_cycles(PERIOD);

  logic [W-1:0] remain_q;
  logic [W-1:0] phase_q;
  logic         idle;

  assign idle = (remain_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
      phase_q  <= '0;
    end else begin
      if (evt)
        remain_q <= W'(PERIOD);
      else if (!idle)
        remain_q <= remain_q - 1'b1;

      if (evt && idle)
        phase_q <= '0;
      else if (!idle)
        phase_q <= (phase_q == W'(PERIOD - 1)) ? '0 : phase_q + 1'b1;
    end
  end

  assign busy = !idle;
  assign lit  = !idle && (phase_q < W'(ON));

endmodule

// File: rtl/led_drive.sv
module led_drive (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] on_next,
  output logic [3:0] led_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) led_n <= '1;
    else        led_n <= ~on_next;
  end
endmodule

// File: rtl/port_led_ctrl.sv
module port_led_ctrl
  import led_ctrl_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 25_000_000,
  parameter int unsigned ACT_HZ  = 10,
  parameter int unsigned COL_HZ  = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_up,
  input  logic speed_100,
  input  logic full_duplex,
  input  logic tx_act,
  input  logic rx_act,
  input  logic col_evt,
  input  logic col_mode,
  output logic led_fast_n,
  output logic led_slow_n,
  output logic led_act_n,
  output logic led_dxcol_n
);
  localparam int unsigned ACT_P = blink_cycles(CLK_HZ, ACT_HZ);
  localparam int unsigned COL_P = blink_cycles(CLK_HZ, COL_HZ);
  localparam int unsigned NCH   = 2;

  // Named event and channel wires, used by the bound checker.
  logic act_evt, col_take;
  logic act_busy, col_busy, act_lit, col_lit;
  logic [NCH-1:0] ch_evt, ch_busy, ch_lit;
  logic [3:0]     on_next, led_n;

  assign act_evt  = (tx_act | rx_act) & link_up;
  assign col_take = col_evt;
  assign ch_evt   = {col_take, act_evt};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int unsigned CH_P = (g == 0) ? ACT_P : COL_P;
    blink_stretch #(.PERIOD(CH_P)) u_ch (
      .clk  (clk),
      .rst_n(rst_n),
      .evt  (ch_evt[g]),
      .busy (ch_busy[g]),
      .lit  (ch_lit[g])
    );
  end

  assign act_busy = ch_busy[0];
  assign col_busy = ch_busy[1];
  assign act_lit  = ch_lit[0];
  assign col_lit  = ch_lit[1];

  always_comb begin
    on_next            = '0;
    on_next[LED_FAST]  = link_up & speed_100;
    on_next[LED_SLOW]  = link_up & ~speed_100;
    on_next[LED_ACT]   = link_up & act_lit;
    on_next[LED_DXCOL] = col_mode ? col_lit : (link_up & full_duplex);
  end

  led_drive u_drv (
    .clk    (clk),
    .rst_n  (rst_n),
    .on_next(on_next),
    .led_n  (led_n)
  );

  assign led_fast_n  = led_n[LED_FAST];
  assign led_slow_n  = led_n[LED_SLOW];
  assign led_act_n   = led_n[LED_ACT];
  assign led_dxcol_n = led_n[LED_DXCOL];

endmodule

// File: rtl/led_ctrl_chk.sv
module led_ctrl_chk #(
  parameter int unsigned ACT_P = 40
) (
  input logic clk,
  input logic rst_n,
  input logic link_up,
  input logic speed_100,
  input logic col_mode,
  input logic act_evt,
  input logic act_busy,
  input logic col_busy,
  input logic led_fast_n,
  input logic led_slow_n,
  input logic led_act_n,
  input logic led_dxcol_n
);
  int unsigned act_gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 act_gap <= ACT_P + 1;
    else if (act_evt)           act_gap <= 0;
    else if (act_gap <= ACT_P)  act_gap <= act_gap + 1;
  end

  // R1
  fast_led_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up && speed_100) |=> !led_fast_n);

  // R2
  slow_led_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up && !speed_100) |=> !led_slow_n);

  // R4
  stretch_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_evt |=> act_busy);

  // R4
  stretch_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_busy) |-> (act_gap == ACT_P));

  // R8
  link_down_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up |=> (led_act_n && led_fast_n && led_slow_n));

  // R6
  col_idle_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_mode && !col_busy) |=> led_dxcol_n);

  // R7
  reset_dark_chk: assert property (@(posedge clk)
    !rst_n |=> (led_fast_n && led_slow_n && led_act_n && led_dxcol_n));

endmodule

bind port_led_ctrl led_ctrl_chk #(.ACT_P(ACT_P)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .link_up    (link_up),
  .speed_100  (speed_100),
  .col_mode   (col_mode),
  .act_evt    (act_evt),
  .act_busy   (act_busy),
  .col_busy   (col_busy),
  .led_fast_n (led_fast_n),
  .led_slow_n (led_slow_n),
  .led_act_n  (led_act_n),
  .led_dxcol_n(led_dxcol_n)
);

// File: tb/port_led_ctrl_test.sv
`timescale 1ns/1ps
module port_led_ctrl_test;
  localparam int unsigned CLK_HZ = 400;
  localparam int AP = CLK_HZ / 10;
  localparam int CP = CLK_HZ / 20;

  logic clk = 0, rst_n = 0;
  logic link_up = 0, speed_100 = 0, full_duplex = 0;
  logic tx_act = 0, rx_act = 0, col_evt = 0, col_mode = 0;
  logic led_fast_n, led_slow_n, led_act_n, led_dxcol_n;

  int checks = 0, fails = 0;
  bit done = 0;
  int e = 0;
  bit a_have = 0, c_have = 0;
  int a_last, a_start, c_last, c_start;
  bit ex_fast, ex_slow, ex_act, ex_dx;

  always #2.5 clk = ~clk;

  port_led_ctrl #(.CLK_HZ(CLK_HZ)) uut (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .speed_100(speed_100),
    .full_duplex(full_duplex), .tx_act(tx_act), .rx_act(rx_act),
    .col_evt(col_evt), .col_mode(col_mode), .led_fast_n(led_fast_n),
    .led_slow_n(led_slow_n), .led_act_n(led_act_n), .led_dxcol_n(led_dxcol_n)
  );

  task automatic chk(input string tag, input bit got, input bit exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s at edge %0d: got %0b expected %0b", tag, e, got, exp);
    end
  endtask

  // Blink state after edge 'at': active within P edges of last event,
  // lit in the leading floor(P/2) cycles counted from the start edge.
  function automatic bit on_at(bit have, int last, int start, int at, int p);
    if (!have || at - last > p - 1) return 0;
    return ((at - start) % p) < (p / 2);
  endfunction

  function automatic bit active_at(bit have, int last, int at, int p);
    return have && (at - last <= p - 1);
  endfunction

  task automatic step(bit lk, bit sp, bit fd, bit tx, bit rx, bit co, bit md);
    bit a_on, c_on, aev;
    link_up = lk; speed_100 = sp; full_duplex = fd;
    tx_act = tx; rx_act = rx; col_evt = co; col_mode = md;
    @(posedge clk);
    e++;
    a_on = on_at(a_have, a_last, a_start, e - 1, AP);
    c_on = on_at(c_have, c_last, c_start, e - 1, CP);
    ex_fast = !(lk && sp);
    ex_slow = !(lk && !sp);
    ex_act  = !(lk && a_on);
    ex_dx   = md ? !c_on : !(lk && fd);
    aev = (tx || rx) && lk;
    if (aev) begin
      if (!active_at(a_have, a_last, e - 1, AP)) a_start = e;
      a_last = e; a_have = 1;
    end
    if (co) begin
      if (!active_at(c_have, c_last, e - 1, CP)) c_start = e;
      c_last = e; c_have = 1;
    end
    @(negedge clk);
    chk("R1", led_fast_n, ex_fast);
    chk("R2", led_slow_n, ex_slow);
    chk(lk ? "R3" : "R8", led_act_n, ex_act);
    chk(md ? "R6" : "R5", led_dxcol_n, ex_dx);
  endtask

  initial begin
    int lit_cnt;
    void'($urandom(32'h5eed_1ed0));
    repeat (3) begin
      @(negedge clk);
      // R7: dark during reset
      chk("R7", led_fast_n & led_slow_n & led_act_n & led_dxcol_n, 1'b1);
    end
    rst_n = 1;
    step(0, 0, 0, 0, 0, 0, 0);
    // R7: dark in the first cycle after reset with no link
    chk("R7", led_fast_n & led_slow_n & led_act_n & led_dxcol_n, 1'b1);

    // R4: single pulse gives exactly floor(P/2) lit cycles
    step(1, 1, 1, 1, 0, 0, 0);
    lit_cnt = 0;
    for (int i = 0; i < 2 * AP; i++) begin
      step(1, 1, 1, 0, 0, 0, 0);
      if (!led_act_n) lit_cnt++;
    end
    chk("R4", lit_cnt == AP / 2, 1'b1);

    // R8: activity while link down is dropped
    step(0, 0, 0, 1, 1, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0);
    lit_cnt = 0;
    for (int i = 0; i < AP; i++) begin
      step(1, 0, 0, 0, 0, 0, 0);
      if (!led_act_n) lit_cnt++;
    end
    chk("R8", lit_cnt == 0, 1'b1);

    // R6: collision pulse with link down, collision mode
    step(0, 0, 0, 0, 0, 1, 1);
    for (int i = 0; i < 2 * CP; i++) step(0, 0, 0, 0, 0, 0, 1);

    // R4: repeated events mid-window keep phase
    for (int i = 0; i < 3 * AP; i++) step(1, 1, 0, (i % 7) == 0 && i < AP, 0, 0, 0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit lk = ($urandom % 16) != 0;
      step(lk, ($urandom % 64) != 0 ? speed_100 ^ (($urandom % 200) == 0) : ~speed_100,
           ($urandom % 50) == 0 ? ~full_duplex : full_duplex,
           ($urandom % 30) == 0, ($urandom % 40) == 0, ($urandom % 45) == 0,
           ($urandom % 300) == 0 ? ~col_mode : col_mode);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule